// File: doc/BRIEF.md
# Multilevel Four-Stage Pipeline Register

This block holds four byte-wide registers, organised as two pairs (first pair: A1 then A2; second pair: B1 then B2). A 2-bit operation code, applied every clock, makes the bank behave either as two separate two-deep pipelines or as a single four-deep pipeline. All loads come from one byte-wide data input.

A 2-bit select routes any one register to a byte-wide output. An output enable gates that output, and when the enable is low the output floats to high impedance.

A compile-time parameter chooses how a pair load treats the old data. In the push-down variant, a pair load moves the old first-level value into the second level. In the overwrite variant, a pair load replaces only the first level. In that variant the second level changes only through the four-deep shift.

Top module: `pipe4_reg`

## Requirements
- R1: A synchronous active-high `rst` clears all four registers to zero on the rising clock edge.
- R2: Operation code 3 leaves all four registers unchanged.
- R3: Operation code 0 shifts the whole chain on the rising edge, in this order: `din` to A1, A1 to A2, A2 to B1, B1 to B2.
- R4: In the push-down variant (`PUSH_DOWN`=1), code 2 writes `din` to A1 and the old A1 to A2. B1 and B2 do not change.
- R5: In the push-down variant, code 1 writes `din` to B1 and the old B1 to B2. A1 and A2 do not change.
- R6: In the overwrite variant (`PUSH_DOWN`=0), code 2 writes `din` to A1 only. A2, B1 and B2 do not change.
- R7: In the overwrite variant, code 1 writes `din` to B1 only. B2, A1 and A2 do not change.
- R8: The output routing follows `sel`: value 0 gives B2, 1 gives B1, 2 gives A2 and 3 gives A1. The routing is combinational from the registers.
- R9: While `oe` is high, `dout` carries the selected register. While `oe` is low, every bit of `dout` is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| op | input | 2 | Operation: 0 shift, 1 load pair B, 2 load pair A, 3 hold |
| din | input | W | Data input |
| sel | input | 2 | Output register select |
| oe | input | 1 | Output enable, active high |
| dout | output | W | Selected register, or high impedance when disabled |

## Verification
The bench runs a push-down instance and an overwrite instance side by side, each against its own reference model. It issues pair-A and pair-B loads back to back, and mixes them with shifts and holds. A variant that pushed when it should overwrite, or the reverse, would leave the wrong byte in a second level. Code 1 and code 2 swapped would land data in the wrong pair. A wrong link in the shift chain would show up once the data reaches B2. Every select value is read with the enable both high and low: a swapped select entry would return a neighbouring register, and a leaky enable would drive data where high impedance is expected. A reset in the middle of the run must wipe values that were just written.

// File: rtl/pipe4_reg.sv
module pipe4_reg #(
  parameter int W         = 8,
  parameter bit PUSH_DOWN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op,
  input  logic [W-1:0] din,
  input  logic [1:0]   sel,
  input  logic         oe,
  output logic [W-1:0] dout
);
  localparam logic [1:0] OP_SHIFT = 2'd0;
  localparam logic [1:0] OP_LDB   = 2'd1;
  localparam logic [1:0] OP_LDA   = 2'd2;

  logic [W-1:0] a1, a2, b1, b2, pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      a1 <= '0; a2 <= '0; b1 <= '0; b2 <= '0;
    end else begin
      case (op)
        OP_SHIFT: begin
          a1 <= din; a2 <= a1; b1 <= a2; b2 <= b1;
        end
        OP_LDB: begin
          b1 <= din;
          if (PUSH_DOWN) b2 <= b1;
        end
        OP_LDA: begin
          a1 <= din;
          if (PUSH_DOWN) a2 <= a1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      2'd0:    pick = b2;
      2'd1:    pick = b1;
      2'd2:    pick = a2;
      default: pick = a1;
    endcase
  end

  assign dout = oe ? pick : 'z;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (a1 == '0 && a2 == '0 && b1 == '0 && b2 == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    op == 2'd3 |=> ($stable(a1) && $stable(a2) && $stable(b1) && $stable(b2)));

  assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
    op == OP_SHIFT |=> (a1 == $past(din) && a2 == $past(a1) &&
                        b1 == $past(a2) && b2 == $past(b1)));

  generate
    if (PUSH_DOWN) begin : g_push
      assert_pusha_R4: assert property (@(posedge clk) disable iff (rst)
        op == OP_LDA |=> (a1 == $past(din) && a2 == $past(a1) && $stable(b1) && $stable(b2)));
      assert_pushb_R5: assert property (@(posedge clk) disable iff (rst)
        op == OP_LDB |=> (b1 == $past(din) && b2 == $past(b1) && $stable(a1) && $stable(a2)));
    end else begin : g_over
      assert_overa_R6: assert property (@(posedge clk) disable iff (rst)
        op == OP_LDA |=> (a1 == $past(din) && $stable(a2) && $stable(b1) && $stable(b2)));
      assert_overb_R7: assert property (@(posedge clk) disable iff (rst)
        op == OP_LDB |=> (b1 == $past(din) && $stable(b2) && $stable(a1) && $stable(a2)));
    end
  endgenerate
endmodule

// File: tb/test_pipe4_reg.sv
module test_pipe4_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op  = 2'd3;
  logic [7:0] din = '0;
  logic [1:0] sel = '0;
  logic       oe  = 1'b0;
  wire  [7:0] yp, yo;

  always #2.5 clk = ~clk;

  pipe4_reg #(.W(8), .PUSH_DOWN(1'b1)) i_pipe4_reg (
    .clk(clk), .rst(rst), .op(op), .din(din), .sel(sel), .oe(oe), .dout(yp));
  pipe4_reg #(.W(8), .PUSH_DOWN(1'b0)) i_pipe4_reg_ow (
    .clk(clk), .rst(rst), .op(op), .din(din), .sel(sel), .oe(oe), .dout(yo));

  typedef struct {
    logic [7:0] ep;
    logic [7:0] eo;
    string      tp;
    string      to;
  } item_t;

  item_t q[$];
  int runs = 0, fails = 0;
  logic [7:0] mp [4];
  logic [7:0] mo [4];

  task automatic model(ref logic [7:0] m [4], input bit push, input logic r,
                       input logic [1:0] o, input logic [7:0] d);
    if (r) begin
      for (int i = 0; i < 4; i++) m[i] = '0;
    end else if (o == 2'd0) begin
      m[3] = m[2]; m[2] = m[1]; m[1] = m[0]; m[0] = d;
    end else if (o == 2'd1) begin
      if (push) m[3] = m[2];
      m[2] = d;
    end else if (o == 2'd2) begin
      if (push) m[1] = m[0];
      m[0] = d;
    end
  endtask

  function automatic string tag(bit push, logic r, logic [1:0] o, logic e);
    string t;
    if (r) t = "R1";
    else case (o)
      2'd0: t = "R3";
      2'd1: t = push ? "R5" : "R7";
      2'd2: t = push ? "R4" : "R6";
      default: t = "R2";
    endcase
    return e ? {t, "/R8"} : {t, "/R9"};
  endfunction

  task automatic drive(input logic r, input logic [1:0] o, input logic [7:0] d,
                       input logic [1:0] s, input logic e);
    item_t it;
    @(negedge clk);
    rst = r; op = o; din = d; sel = s; oe = e;
    model(mp, 1'b1, r, o, d);
    model(mo, 1'b0, r, o, d);
    it.ep = e ? mp[3 - s] : 8'hzz;
    it.eo = e ? mo[3 - s] : 8'hzz;
    it.tp = tag(1'b1, r, o, e);
    it.to = tag(1'b0, r, o, e);
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    item_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      runs += 2;
      if (yp !== it.ep) begin
        fails++;
        $display("FAIL %s push-down: got %h expected %h", it.tp, yp, it.ep);
      end
      if (yo !== it.eo) begin
        fails++;
        $display("FAIL %s overwrite: got %h expected %h", it.to, yo, it.eo);
      end
    end
  end

  task automatic sweep();
    for (int s = 0; s < 4; s++) begin
      drive(1'b0, 2'd3, 8'hEE, 2'(s), 1'b1);
      drive(1'b0, 2'd3, 8'hEE, 2'(s), 1'b0);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin mp[i] = 'x; mo[i] = 'x; end
    drive(1'b1, 2'd3, 8'h00, 2'd0, 1'b1);
    drive(1'b1, 2'd3, 8'h00, 2'd3, 1'b1);
    sweep();                                   // R1 R8 R9 after reset
    drive(1'b0, 2'd0, 8'h11, 2'd3, 1'b1);      // R3 shift fill
    drive(1'b0, 2'd0, 8'h22, 2'd2, 1'b1);
    drive(1'b0, 2'd0, 8'h33, 2'd1, 1'b1);
    drive(1'b0, 2'd0, 8'h44, 2'd0, 1'b1);
    sweep();                                   // R2 R8 R9
    drive(1'b0, 2'd2, 8'hA5, 2'd3, 1'b1);      // R4 R6 back to back
    drive(1'b0, 2'd2, 8'h5A, 2'd2, 1'b1);
    drive(1'b0, 2'd1, 8'hC3, 2'd1, 1'b1);      // R5 R7
    drive(1'b0, 2'd1, 8'h3C, 2'd0, 1'b1);
    drive(1'b0, 2'd2, 8'h77, 2'd2, 1'b1);
    drive(1'b0, 2'd1, 8'h88, 2'd0, 1'b0);
    sweep();
    drive(1'b0, 2'd0, 8'h99, 2'd0, 1'b1);      // shift after loads
    drive(1'b0, 2'd3, 8'hFF, 2'd1, 1'b1);
    drive(1'b0, 2'd1, 8'h01, 2'd0, 1'b1);
    drive(1'b0, 2'd0, 8'h02, 2'd0, 1'b1);
    drive(1'b0, 2'd2, 8'h03, 2'd2, 1'b1);
    drive(1'b0, 2'd0, 8'h04, 2'd1, 1'b1);
    sweep();
    drive(1'b1, 2'd0, 8'hAA, 2'd3, 1'b1);      // R1 mid-run
    sweep();
    for (int k = 0; k < 40; k++)
      drive(1'b0, 2'(k * 7 % 4), 8'(k * 37 + 5), 2'(k * 3 % 4), 1'((k % 5) != 0));
    sweep();
    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule